// File: doc/BRIEF.md
# Parity Fault Capture Status Register

This block is a single 32-bit status register that sits on a simple memory-mapped bus beside a small local RAM. When the RAM's parity checker reports a failing byte, the register raises a fault flag and records the byte offset of that location. Further errors still raise the flag. The recorded offset stays fixed until software reads the register in a way that covers its lower half-word, so the offset shown always belongs to the first fault after the last acknowledgement.

Software acknowledges a fault in one of two ways. It can read the lower half-word or the whole word, which clears the flag and releases the offset. It can also write a one to the flag bit from a privileged access. A debug-mode input removes every side effect of reads, so a debugger can inspect the register without changing it. The recorded offset has no reset and survives every reset of the block. Read data is registered and appears one cycle after the read strobe. Byte lanes that the read does not select return zero.

Top module: `pcsr_status_reg`

## Requirements
- R1: The fault flag reads at bit 16 and the 9-bit offset reads at bits 8..0. Every other bit reads 0, and writes to those bits change nothing.
- R2: The flag is set by an error pulse only while the check-enable input is high. An error pulse with check-enable low changes neither the flag nor the offset. An enabled error sets the flag even while the offset is frozen.
- R3: An enabled error that arrives while the offset is not frozen stores that error's byte offset and freezes it.
- R4: While the offset is frozen, later errors do not overwrite it.
- R5: A non-debug read at the register address with byte selects 1 and 0 both high clears the flag and unfreezes the offset. The data returned is the value from before the clear, on the cycle after the strobe, with unselected byte lanes reading 0.
- R6: A write at the register address with data bit 16 high and privilege high clears the flag. An unprivileged write, or a write with bit 16 low, leaves the flag unchanged.
- R7: While debug mode is high, reads clear neither the flag nor the frozen state.
- R8: Reset clears the flag and the frozen state. The stored offset keeps its value through reset.
- R9: A read whose byte selects do not include both lanes 0 and 1 (for example upper lanes only, selects 4'b1100) has no side effect.
- R10: When an enabled error coincides with a clearing read, the read returns the old value. The flag then stays set, the new error's offset is stored, and the offset is frozen again.
- R11: Reads and writes at any other address have no effect, and such reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (the offset is not reset) |
| err_pulse | input | 1 | One-cycle parity error indication from the RAM checker |
| err_offset | input | 9 | Byte offset of the failing RAM location |
| chk_en | input | 1 | Parity checking enabled |
| dbg_mode | input | 1 | Debug mode: reads have no side effect |
| priv_mode | input | 1 | Current access is privileged |
| bus_addr | input | 8 | Register address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rd_be | input | 4 | Byte-lane read selects |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The internal frozen bit is never visible directly. A wrong value shows up only on a later read, where the offset reflects a second error that it should have ignored, or stays stale when it should have taken a new one. The bench therefore places error pulses between reads of different lane coverage and debug states, and reads back the offset on the next full read, one cycle after the strobe. A flag fault appears on the very next read. Each acknowledgement path is followed by an upper-lane read, which has no side effect, so a missed or spurious clear appears at once.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;
    localparam int DATA_W   = 32;
    localparam int LANES    = DATA_W / 8;
    localparam int OFF_W    = 9;
    localparam int FLAG_BIT = 16;

    typedef struct packed {
        logic rd_hit;   // read at this register
        logic clr_rd;   // read with side effects (lower half covered, not debug)
        logic w1c;      // privileged write-one to the flag bit
    } pcsr_acc_t;
endpackage

// File: rtl/pcsr_access_decode.sv
module pcsr_access_decode
    import pcsr_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h20
) (
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANES-1:0]  bus_rd_be,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              dbg_mode,
    input  logic              priv_mode,
    output pcsr_acc_t         acc
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

    logic hit;
    logic lower_half;

    always_comb begin
        hit        = (bus_addr == MATCH);
        lower_half = bus_rd_be[0] && bus_rd_be[1];
        acc.rd_hit = bus_rd && hit;
        acc.clr_rd = bus_rd && hit && lower_half && !dbg_mode;
        acc.w1c    = bus_wr && hit && priv_mode && bus_wdata[FLAG_BIT];
    end
endmodule

// File: rtl/pcsr_fault_flag.sv
module pcsr_fault_flag
    import pcsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      err_pulse,
    input  logic      chk_en,
    input  logic      dbg_mode,
    input  pcsr_acc_t acc,
    output logic      flag_q
);
    typedef struct packed {
        logic flag;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (err_pulse && chk_en) begin
            st_d.flag = 1'b1;
        end else if (acc.clr_rd || acc.w1c) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q = st_q.flag;

    AST_FLAG_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(err_pulse && chk_en)); // R2
    AST_FLAG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(acc.clr_rd || acc.w1c)); // R6
    AST_DBG_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && dbg_mode && !acc.w1c) |=> flag_q); // R7
endmodule

// File: rtl/pcsr_offset_capture.sv
module pcsr_offset_capture
    import pcsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_pulse,
    input  logic [OFF_W-1:0] err_offset,
    input  logic             chk_en,
    input  pcsr_acc_t        acc,
    output logic [OFF_W-1:0] offset_q
);
    typedef struct packed {
        logic             frozen;
        logic [OFF_W-1:0] offset;
    } cap_st_t;

    cap_st_t st_d;
    logic    frozen_q;
    logic    capture;

    always_comb begin
        capture       = err_pulse && chk_en && (!frozen_q || acc.clr_rd);
        st_d.frozen   = frozen_q;
        st_d.offset   = offset_q;
        if (capture) begin
            st_d.frozen = 1'b1;
            st_d.offset = err_offset;
        end else if (acc.clr_rd) begin
            st_d.frozen = 1'b0;
        end
    end

    // Frozen state follows the block reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frozen_q <= 1'b0;
        end else begin
            frozen_q <= st_d.frozen;
        end
    end

    // Offset storage has no reset at all.
    always_ff @(posedge clk) begin
        offset_q <= st_d.offset;
    end

    AST_OFFSET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_q && !acc.clr_rd) |=> $stable(offset_q)); // R4
    AST_CAPTURE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && chk_en && !frozen_q) |=> (offset_q == $past(err_offset))); // R3
endmodule

// File: rtl/pcsr_status_reg.sv
module pcsr_status_reg
    import pcsr_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] REG_ADDR = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_pulse,
    input  logic [8:0]        err_offset,
    input  logic              chk_en,
    input  logic              dbg_mode,
    input  logic              priv_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [3:0]        bus_rd_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam logic [DATA_W-1:0] LIVE_MASK =
        (DATA_W'(1) << FLAG_BIT) | ((DATA_W'(1) << OFF_W) - DATA_W'(1));

    pcsr_acc_t         acc;
    logic              flag_q;
    logic [OFF_W-1:0]  offset_q;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    pcsr_access_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_rd_be (bus_rd_be),
        .bus_wdata (bus_wdata),
        .dbg_mode  (dbg_mode),
        .priv_mode (priv_mode),
        .acc       (acc)
    );

    pcsr_fault_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_pulse (err_pulse),
        .chk_en    (chk_en),
        .dbg_mode  (dbg_mode),
        .acc       (acc),
        .flag_q    (flag_q)
    );

    pcsr_offset_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_pulse  (err_pulse),
        .err_offset (err_offset),
        .chk_en     (chk_en),
        .acc        (acc),
        .offset_q   (offset_q)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_mask[l*8 +: 8] = {8{bus_rd_be[l]}};
    end

    always_comb begin
        word                 = '0;
        word[FLAG_BIT]       = flag_q;
        word[OFF_W-1:0]      = offset_q;
        rdata_d              = rdata_q;
        if (acc.rd_hit) begin
            rdata_d = word & lane_mask;
        end else if (bus_rd) begin
            rdata_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;

    always_comb begin
        if (rst_n) begin
            AST_RESERVED_ZERO: assert ((rdata_q & ~LIVE_MASK) == '0); // R1
        end
    end
endmodule

// File: tb/tb_pcsr_status_reg.sv
module tb_pcsr_status_reg;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] RA = 8'h20;
    localparam logic [31:0] FLAGW = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        err_pulse, chk_en, dbg_mode, priv_mode;
    logic [8:0]  err_offset;
    logic [7:0]  bus_addr;
    logic        bus_rd, bus_wr;
    logic [3:0]  bus_rd_be;
    logic [31:0] bus_wdata, bus_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] r;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcsr_status_reg dut (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .err_offset(err_offset),
        .chk_en(chk_en), .dbg_mode(dbg_mode), .priv_mode(priv_mode),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_rd_be(bus_rd_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        err_pulse = 0; bus_rd = 0; bus_wr = 0; bus_rd_be = 0;
        bus_wdata = 0; bus_addr = RA; dbg_mode = 0; priv_mode = 0;
    endtask

    task automatic err(input logic [8:0] off, input logic en);
        err_pulse = 1; err_offset = off; chk_en = en;
        tick();
        err_pulse = 0; chk_en = 1;
    endtask

    task automatic rd(input logic [7:0] a, input logic [3:0] be, input logic dbg,
                      output logic [31:0] data);
        bus_addr = a; bus_rd = 1; bus_rd_be = be; dbg_mode = dbg;
        tick();
        idle();
        data = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic pv);
        bus_addr = a; bus_wr = 1; bus_wdata = d; priv_mode = pv;
        tick();
        idle();
    endtask

    task automatic t_reset();
        rd(RA, 4'hF, 0, r);
        chk("R8 flag after reset", r & FLAGW, 32'h0);
        chk("R1 reserved bits zero", r & 32'hFFFE_FE00, 32'h0);
    endtask

    task automatic t_disabled();
        err(9'h007, 0);
        rd(RA, 4'b1100, 0, r);
        chk("R2 disabled error leaves flag", r, 32'h0);
    endtask

    task automatic t_capture();
        err(9'h1A5, 1);
        rd(RA, 4'b1100, 0, r);
        chk("R9 upper read data", r, FLAGW);
        err(9'h033, 1);
        rd(RA, 4'hF, 0, r);
        chk("R3 R4 first offset kept", r, FLAGW | 32'h1A5);
        rd(RA, 4'hF, 0, r);
        chk("R5 flag cleared by full read", r, 32'h1A5);
        err(9'h0F0, 1);
        rd(RA, 4'b0011, 0, r);
        chk("R5 half read masks lanes", r, 32'h0F0);
        rd(RA, 4'hF, 0, r);
        chk("R5 half read cleared flag", r, 32'h0F0);
    endtask

    task automatic t_upper();
        err(9'h011, 1);
        rd(RA, 4'b1100, 0, r);
        rd(RA, 4'b0100, 0, r);
        chk("R9 upper reads keep flag", r, FLAGW);
        rd(RA, 4'b0001, 0, r);
        chk("R9 single low byte read", r, 32'h11);
        err(9'h022, 1);
        rd(RA, 4'hF, 0, r);
        chk("R9 partial reads kept freeze", r, FLAGW | 32'h011);
    endtask

    task automatic t_debug();
        err(9'h055, 1);
        rd(RA, 4'hF, 1, r);
        chk("R7 debug read data", r, FLAGW | 32'h055);
        rd(RA, 4'hF, 1, r);
        chk("R7 debug read keeps flag", r, FLAGW | 32'h055);
        err(9'h066, 1);
        rd(RA, 4'hF, 0, r);
        chk("R7 debug read kept freeze", r, FLAGW | 32'h055);
    endtask

    task automatic t_w1c();
        err(9'h101, 1);
        wr(RA, FLAGW, 0);
        rd(RA, 4'b1100, 0, r);
        chk("R6 unprivileged write ignored", r, FLAGW);
        wr(RA, 32'hFFFE_FFFF, 1);
        rd(RA, 4'b1100, 0, r);
        chk("R6 R1 write of zero flag bit ignored", r, FLAGW);
        wr(RA, FLAGW, 1);
        rd(RA, 4'b1100, 0, r);
        chk("R6 privileged write one clears", r, 32'h0);
        err(9'h102, 1);
        rd(RA, 4'hF, 0, r);
        chk("R2 R4 frozen error sets flag only", r, FLAGW | 32'h101);
    endtask

    task automatic t_collide();
        err(9'h0AA, 1);
        bus_addr = RA; bus_rd = 1; bus_rd_be = 4'hF;
        err_pulse = 1; err_offset = 9'h0BB; chk_en = 1;
        tick();
        idle(); err_pulse = 0;
        chk("R10 collide read returns old", bus_rdata, FLAGW | 32'h0AA);
        rd(RA, 4'b1100, 0, r);
        chk("R10 flag stays set", r, FLAGW);
        err(9'h0CD, 1);
        rd(RA, 4'hF, 0, r);
        chk("R10 new offset captured and frozen", r, FLAGW | 32'h0BB);
    endtask

    task automatic t_other();
        err(9'h0CC, 1);
        rd(8'h24, 4'hF, 0, r);
        chk("R11 other address reads zero", r, 32'h0);
        wr(8'h24, FLAGW, 1);
        rd(RA, 4'b1100, 0, r);
        chk("R11 other address write ignored", r, FLAGW);
        rd(RA, 4'hF, 0, r);
        chk("R11 other read kept freeze", r, FLAGW | 32'h0CC);
    endtask

    task automatic t_reset_keep();
        err(9'h1F0, 1);
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
        rd(RA, 4'hF, 0, r);
        chk("R8 offset survives reset", r, 32'h1F0);
    endtask

    initial begin
        idle();
        err_offset = 0; chk_en = 1; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        t_reset();
        t_disabled();
        t_capture();
        t_upper();
        t_debug();
        t_w1c();
        t_collide();
        t_other();
        t_reset_keep();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule